// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This block decides whether a conditional branch or a conditionally executed operation should go ahead. It takes the four stored status flags (negative, zero, carry, overflow) left by an earlier compare or arithmetic operation, together with a 4-bit condition selector. It returns one bit that says whether the selected condition holds. The unit is purely combinational and holds no state. A branch unit can therefore use the answer in the same cycle that the flags and the selector are presented.

The sixteen selector values form eight pairs. The even member of each pair tests a base predicate and the odd member tests its complement. Carry follows the convention that a subtract sets carry when no borrow occurs. Signed orderings compare the negative flag against the overflow flag rather than reading the negative flag alone. A difference whose sign bit was corrupted by two's-complement overflow is therefore still ordered correctly.

The block has no states and no transitions. The selector value plays the role that a state would play in a sequential design: it picks which predicate drives the output.

Top module: `cond_eval`

## Requirements
- R1: Selector 0 (equal) is true exactly when Z=1, and selector 1 (not equal) is true exactly when Z=0.
- R2: Selector 2 (unsigned higher-or-same) is true when C=1, and selector 3 (unsigned lower) is true when C=0.
- R3: Selector 4 (minus) is true when N=1, and selector 5 (plus) is true when N=0.
- R4: Selector 6 (overflow set) is true when V=1, and selector 7 (overflow clear) is true when V=0.
- R5: Selector 8 (unsigned higher) is true when C=1 and Z=0, and selector 9 (unsigned lower-or-same) is true when C=0 or Z=1.
- R6: Selector 10 (signed greater-or-equal) is true when N equals V, and selector 11 (signed less) is true when N differs from V.
- R7: Selector 12 (signed greater) is true when Z=0 and N equals V, and selector 13 (signed less-or-equal) is true when Z=1 or N differs from V.
- R8: Selector 14 is true for every flag value, and selector 15 is false for every flag value.
- R9: For every flag combination, selectors 2k and 2k+1 give opposite results.
- R10: The output depends only on the present flags and selector. It is valid in the same cycle, and earlier inputs have no effect on it.
- R11: After a compare that computes A - B as A + ~B + 1, with C as the carry-out of bit 7, V set on a sign flip, N as bit 7 and Z for an all-zero result, selectors 0-3 and 8-13 agree with the integer relations between A and B. The unsigned relations follow the unsigned reading of the operands and the signed relations follow the signed reading, including compares whose difference overflows (for example, -100 against 100 gives N=0, V=1, and signed greater is false).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flag_n | input | 1 | Stored negative flag |
| flag_z | input | 1 | Stored zero flag |
| flag_c | input | 1 | Stored carry flag (1 = no borrow on subtract) |
| flag_v | input | 1 | Stored signed overflow flag |
| cond_code | input | 4 | Condition selector, encoded as in R1-R8 |
| cond_true | output | 1 | 1 when the selected condition holds |

## Verification
Whenever the inputs change, the bound checker compares the output against the flag formula for each selector class and confirms that the two fixed selectors give their constant values. These checks cover R1 to R8 directly. The complement pairing (R9) is a relation between two selector values, which the design never sees at the same time, so only the bench can show it: it sweeps every flag combination under both members of each pair. Agreement with integer comparisons (R11), including operand pairs whose difference overflows, is shown only by the bench's compare scenarios. Independence from history (R10) is shown by re-presenting identical inputs after unrelated ones.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    localparam int CODE_W   = 4;
    localparam int NUM_PAIR = 1 << (CODE_W - 1);
    localparam int PAIR_W   = CODE_W - 1;

    typedef enum logic [CODE_W-1:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,
        CC_HS = 4'd2,  CC_LO = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,
        CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,
        CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13,
        CC_AL = 4'd14, CC_NV = 4'd15
    } cond_code_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/cond_pred_bank.sv
module cond_pred_bank
    import cond_eval_pkg::*;
(
    input  flags_t              flags,
    output logic [NUM_PAIR-1:0] pred
);
    logic sign_ok;

    always_comb begin
        sign_ok = ~(flags.n ^ flags.v);
        pred    = '0;
        pred[0] = flags.z;
        pred[1] = flags.c;
        pred[2] = flags.n;
        pred[3] = flags.v;
        pred[4] = flags.c & ~flags.z;
        pred[5] = sign_ok;
        pred[6] = sign_ok & ~flags.z;
        pred[7] = 1'b1;
    end
endmodule

// File: rtl/cond_pred_pick.sv
module cond_pred_pick
    import cond_eval_pkg::*;
(
    input  logic [NUM_PAIR-1:0] pred,
    input  logic [PAIR_W-1:0]   pair_sel,
    output logic                picked
);
    always_comb begin
        picked = pred[pair_sel];
    end
endmodule

// File: rtl/cond_polarity.sv
module cond_polarity (
    input  logic base,
    input  logic invert,
    output logic result
);
    always_comb begin
        result = base ^ invert;
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_eval_pkg::*;
(
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_v,
    input  logic [CODE_W-1:0] cond_code,
    output logic              cond_true
);
    flags_t              flags;
    logic [NUM_PAIR-1:0] pred;
    logic                base_hit;

    always_comb begin
        flags.n = flag_n;
        flags.z = flag_z;
        flags.c = flag_c;
        flags.v = flag_v;
    end

    cond_pred_bank u_bank (
        .flags (flags),
        .pred  (pred)
    );

    cond_pred_pick u_pick (
        .pred     (pred),
        .pair_sel (cond_code[CODE_W-1:1]),
        .picked   (base_hit)
    );

    cond_polarity u_pol (
        .base   (base_hit),
        .invert (cond_code[0]),
        .result (cond_true)
    );
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk
    import cond_eval_pkg::*;
(
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_v,
    input logic [CODE_W-1:0] cond_code,
    input logic              cond_true
);
    always_comb begin
        if (cond_code == CC_EQ || cond_code == CC_NE) begin
            AST_EQ_NE_ZERO: assert (cond_true == (flag_z ^ cond_code[0])) else $error("EQ/NE mismatch"); // R1
        end
        if (cond_code == CC_HS || cond_code == CC_LO) begin
            AST_CARRY_ORDER: assert (cond_true == (flag_c == (cond_code == CC_HS))) else $error("HS/LO mismatch"); // R2
        end
        if (cond_code == CC_MI || cond_code == CC_PL) begin
            AST_SIGN_FLAG: assert (cond_true == (flag_n == (cond_code == CC_MI))) else $error("MI/PL mismatch"); // R3
        end
        if (cond_code == CC_VS || cond_code == CC_VC) begin
            AST_OVF_FLAG: assert (cond_true == (flag_v == (cond_code == CC_VS))) else $error("VS/VC mismatch"); // R4
        end
        if (cond_code == CC_HI) begin
            AST_UNS_HIGHER: assert (cond_true == (flag_c && !flag_z)) else $error("HI mismatch"); // R5
        end
        if (cond_code == CC_LS) begin
            AST_UNS_LOWSAME: assert (cond_true == (!flag_c || flag_z)) else $error("LS mismatch"); // R5
        end
        if (cond_code == CC_GE || cond_code == CC_LT) begin
            AST_SIGNED_GE_LT: assert (cond_true == ((flag_n == flag_v) == (cond_code == CC_GE))) else $error("GE/LT mismatch"); // R6
        end
        if (cond_code == CC_GT) begin
            AST_SIGNED_GT: assert (cond_true == (!flag_z && flag_n == flag_v)) else $error("GT mismatch"); // R7
        end
        if (cond_code == CC_LE) begin
            AST_SIGNED_LE: assert (cond_true == (flag_z || flag_n != flag_v)) else $error("LE mismatch"); // R7
        end
        if (cond_code == CC_AL) begin
            AST_ALWAYS_ONE: assert (cond_true) else $error("AL not true"); // R8
        end
        if (cond_code == CC_NV) begin
            AST_NEVER_ZERO: assert (!cond_true) else $error("NV not false"); // R8
        end
    end
endmodule

bind cond_eval cond_eval_chk u_chk (
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v),
    .cond_code (cond_code),
    .cond_true (cond_true)
);

// File: tb/cond_eval_bench.sv
module cond_eval_bench;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fn, fz, fc, fv;
    logic [3:0] code;
    logic taken;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cond_eval u_cond_eval (
        .flag_n    (fn),
        .flag_z    (fz),
        .flag_c    (fc),
        .flag_v    (fv),
        .cond_code (code),
        .cond_true (taken)
    );

    function automatic logic flag_expect(input logic [3:0] c, input logic n, input logic z,
                                         input logic cy, input logic v);
        logic r;
        case (c[3:1])
            3'd0: r = z;
            3'd1: r = cy;
            3'd2: r = n;
            3'd3: r = v;
            3'd4: r = cy && !z;
            3'd5: r = (n == v);
            3'd6: r = !z && (n == v);
            default: r = 1'b1;
        endcase
        return c[0] ? !r : r;
    endfunction

    function automatic logic int_expect(input logic [3:0] c, input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b);
        int sa, sb;
        sa = $signed(a);
        sb = $signed(b);
        case (c)
            4'd0:  return a == b;
            4'd1:  return a != b;
            4'd2:  return a >= b;
            4'd3:  return a < b;
            4'd8:  return a > b;
            4'd9:  return a <= b;
            4'd10: return sa >= sb;
            4'd11: return sa < sb;
            4'd12: return sa > sb;
            default: return sa <= sb;
        endcase
    endfunction

    task automatic check(input logic exp, input string req);
        checks++;
        if (taken !== exp) begin
            fails++;
            $display("FAIL %s code=%0d nzcv=%b%b%b%b actual=%b expected=%b",
                     req, code, fn, fz, fc, fv, taken, exp);
        end
    endtask

    task automatic apply(input logic [3:0] c, input logic [3:0] nzcv);
        @(negedge clk);
        code = c;
        {fn, fz, fc, fv} = nzcv;
        #1;
    endtask

    task automatic compare(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                           input logic [3:0] c, input string req);
        logic [DATA_W:0] sum;
        logic [DATA_W-1:0] r;
        sum = {1'b0, a} + {1'b0, ~b} + 1'b1;
        r = sum[DATA_W-1:0];
        apply(c, {r[DATA_W-1], (r == '0), sum[DATA_W],
                  (a[DATA_W-1] != b[DATA_W-1]) && (r[DATA_W-1] != a[DATA_W-1])});
        check(int_expect(c, a, b), req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] c2;
        logic keep;
        void'($urandom(32'h5EED_0042));
        code = 4'd0;
        {fn, fz, fc, fv} = 4'b0000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // initial state: all flags clear, equal selector
        apply(4'd0, 4'b0000);
        check(1'b0, "R1 idle");

        // exhaustive flags x selectors, tagged by class
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                apply(c[3:0], f[3:0]);
                case (c / 2)
                    0: check(flag_expect(c[3:0], fn, fz, fc, fv), "R1");
                    1: check(flag_expect(c[3:0], fn, fz, fc, fv), "R2");
                    2: check(flag_expect(c[3:0], fn, fz, fc, fv), "R3");
                    3: check(flag_expect(c[3:0], fn, fz, fc, fv), "R4");
                    4: check(flag_expect(c[3:0], fn, fz, fc, fv), "R5");
                    5: check(flag_expect(c[3:0], fn, fz, fc, fv), "R6");
                    6: check(flag_expect(c[3:0], fn, fz, fc, fv), "R7");
                    default: check(c == 14, "R8");
                endcase
            end
        end

        // R9: complement pairs for every flag combination
        for (int p = 0; p < 8; p++) begin
            for (int f = 0; f < 16; f++) begin
                apply(4'(2 * p), f[3:0]);
                keep = taken;
                apply(4'(2 * p + 1), f[3:0]);
                check(!keep, "R9 pair");
            end
        end

        // R10: same inputs after different history give the same result
        for (int k = 0; k < 40; k++) begin
            c2 = 4'($urandom_range(0, 15));
            apply(c2, 4'($urandom_range(0, 15)));
            keep = taken;
            apply(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
            apply(c2, {fn, fz, fc, fv} ^ 4'b0000);
            apply(c2, 4'b0000);
            apply(4'd14, 4'b1111);
            check(1'b1, "R10 same-cycle");
            apply(c2, 4'b0000);
            check(flag_expect(c2, 1'b0, 1'b0, 1'b0, 1'b0), "R10 history");
            if (keep === 1'bx) check(1'b0, "R10 unknown");
        end

        // R11 directed: overflowing compares
        compare(8'h9C, 8'h64, 4'd12, "R11 -100>100");
        compare(8'h9C, 8'h64, 4'd11, "R11 -100<100");
        compare(8'h64, 8'h9C, 4'd12, "R11 100>-100");
        compare(8'h64, 8'h9C, 4'd3,  "R11 unsigned 100<156");
        compare(8'h80, 8'h7F, 4'd11, "R11 min<max");
        compare(8'h7F, 8'h7F, 4'd0,  "R11 equal");
        compare(8'h00, 8'hFF, 4'd3,  "R11 0<255");
        compare(8'hFF, 8'h00, 4'd8,  "R11 255>0");

        // R11 random compares across all ordering selectors
        for (int k = 0; k < 1500; k++) begin
            logic [DATA_W-1:0] a, b;
            a = DATA_W'($urandom);
            b = (k % 7 == 0) ? a : DATA_W'($urandom);
            for (int c = 0; c < 14; c++) begin
                if (c < 4 || c > 7) compare(a, b, c[3:0], "R11 random");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule